// File: doc/BRIEF.md
# Shared-Memory Fetch and Address Path

This block is the front end of a multi-cycle processor whose instructions and data sit in one memory behind one port. It owns the program counter and the instruction register, and it chooses what goes onto the memory address lines. A one-bit select from the control word puts either the program counter or a data-bus value on that address.

The instruction register and the program counter change only when their control bits ask for it. An instruction that has been fetched therefore stays in place across all the micro-operations that execute it. The program counter either steps by one or takes a relative branch. The branch offset is a signed field cut from the held instruction. Both updates take effect only in cycles where the select points at the program counter, which are the instruction-fetch cycles. In data cycles the control bits that would change the program counter or the instruction register have no effect.

Top module: `sfa_fetch_path`

## Requirements
- R1: When `sel_data` is 0 (fetch position), `mem_addr` equals `pc` in the same cycle.
- R2: When `sel_data` is 1 (data position), `mem_addr` equals `bus_a` in the same cycle.
- R3: When `ir_load` is 1 and `sel_data` is 0 at a rising edge, `instr` holds the value `mem_rdata` had at that edge.
- R4: At any other edge, including one where `ir_load` is 1 while `sel_data` is 1, `instr` keeps its value.
- R5: When `pc_inc` is 1, `pc_rel` is 0 and `sel_data` is 0 at an edge, `pc` becomes `pc + 1` modulo 2^16.
- R6: When `pc_rel` is 1 and `sel_data` is 0 at an edge, `pc` becomes `pc` plus `instr[5:0]`, read as a two's-complement value from -32 to +31, modulo 2^16. The `instr` used is the value held before that edge.
- R7: When `pc_inc` and `pc_rel` are both 1, the relative load of R6 wins and no extra increment is added.
- R8: When `sel_data` is 1, or when both `pc_inc` and `pc_rel` are 0, `pc` keeps its value across the edge.
- R9: A synchronous active-high `rst` clears `pc` and `instr` to 0 at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_data | input | 1 | Address select: 0 picks the program counter, 1 picks the data bus |
| ir_load | input | 1 | Instruction register load enable |
| pc_inc | input | 1 | Program counter increment enable |
| pc_rel | input | 1 | Program counter relative-branch load enable |
| bus_a | input | 16 | Data address from the datapath |
| mem_rdata | input | 16 | Read data returned by the shared memory |
| mem_addr | output | 16 | Address driven to the shared memory |
| instr | output | 16 | Instruction held in the instruction register |
| pc | output | 16 | Current program counter |

## Verification
The hardest case to reach is a branch with a negative offset. Its offset is not a port: it must first be fetched into the instruction register, and it must still be there after unrelated data cycles when the branch fires. The bench writes an offset such as -4 onto the read data in a fetch cycle with the load bit set. It then runs data cycles that raise every update bit, checks that nothing moved, and only then asserts the branch, with and without the increment bit. Random control words with a fixed seed then mix loads, data cycles and branches across the offset range.

// File: rtl/sfa_pkg.sv
package sfa_pkg;

    localparam int unsigned SFA_ADDR_W  = 16;
    localparam int unsigned SFA_INSTR_W = 16;
    localparam int unsigned SFA_OFF_W   = 6;
    localparam int unsigned SFA_OFF_LSB = 0;

    typedef enum logic {
        SRC_PC  = 1'b0,
        SRC_BUS = 1'b1
    } addr_src_e;

    typedef enum logic [1:0] {
        PC_HOLD = 2'd0,
        PC_INC  = 2'd1,
        PC_REL  = 2'd2
    } pc_op_e;

    typedef struct packed {
        logic sel_data;
        logic ir_load;
        logic pc_inc;
        logic pc_rel;
    } ctl_word_t;

    typedef struct packed {
        addr_src_e src;
        logic      ir_we;
        pc_op_e    pc_op;
    } ctl_dec_t;

    // A fetch cycle is the only one in which sequencing state may change.
    function automatic ctl_dec_t decode_ctl(input ctl_word_t cw);
        ctl_dec_t d;
        d.src   = cw.sel_data ? SRC_BUS : SRC_PC;
        d.ir_we = cw.ir_load && !cw.sel_data;
        if (cw.sel_data)    d.pc_op = PC_HOLD;
        else if (cw.pc_rel) d.pc_op = PC_REL;
        else if (cw.pc_inc) d.pc_op = PC_INC;
        else                d.pc_op = PC_HOLD;
        return d;
    endfunction

endpackage

// File: rtl/sfa_ctl_decode.sv
module sfa_ctl_decode
    import sfa_pkg::*;
(
    input  ctl_word_t cw,
    output ctl_dec_t  dec
);
    always_comb begin
        dec = decode_ctl(cw);
    end
endmodule

// File: rtl/sfa_addr_mux.sv
module sfa_addr_mux
    import sfa_pkg::*;
#(
    parameter int unsigned ADDR_W = SFA_ADDR_W
) (
    input  addr_src_e         src,
    input  logic [ADDR_W-1:0] pc_addr,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic [ADDR_W-1:0] addr
);
    always_comb begin
        unique case (src)
            SRC_PC:  addr = pc_addr;
            SRC_BUS: addr = bus_addr;
            default: addr = pc_addr;
        endcase
    end
endmodule

// File: rtl/sfa_instr_reg.sv
module sfa_instr_reg
    import sfa_pkg::*;
#(
    parameter int unsigned INSTR_W = SFA_INSTR_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [INSTR_W-1:0] d,
    output logic [INSTR_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (we) q <= d;
    end
endmodule

// File: rtl/sfa_pc_unit.sv
module sfa_pc_unit
    import sfa_pkg::*;
#(
    parameter int unsigned ADDR_W = SFA_ADDR_W,
    parameter int unsigned OFF_W  = SFA_OFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  pc_op_e            op,
    input  logic [OFF_W-1:0]  offset,
    output logic [ADDR_W-1:0] pc
);
    localparam int unsigned EXT_W = ADDR_W - OFF_W;

    logic [ADDR_W-1:0] off_ext;
    logic [ADDR_W-1:0] pc_next;

    generate
        if (EXT_W > 0) begin : g_ext
            assign off_ext = {{EXT_W{offset[OFF_W-1]}}, offset};
        end else begin : g_noext
            assign off_ext = offset[ADDR_W-1:0];
        end
    endgenerate

    always_comb begin
        unique case (op)
            PC_INC:  pc_next = pc + ADDR_W'(1);
            PC_REL:  pc_next = pc + off_ext;
            default: pc_next = pc;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) pc <= '0;
        else     pc <= pc_next;
    end
endmodule

// File: rtl/sfa_fetch_path.sv
module sfa_fetch_path
    import sfa_pkg::*;
#(
    parameter int unsigned ADDR_W  = SFA_ADDR_W,
    parameter int unsigned INSTR_W = SFA_INSTR_W,
    parameter int unsigned OFF_W   = SFA_OFF_W,
    parameter int unsigned OFF_LSB = SFA_OFF_LSB
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sel_data,
    input  logic               ir_load,
    input  logic               pc_inc,
    input  logic               pc_rel,
    input  logic [ADDR_W-1:0]  bus_a,
    input  logic [INSTR_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [INSTR_W-1:0] instr,
    output logic [ADDR_W-1:0]  pc
);
    ctl_word_t cw;
    ctl_dec_t  dec;

    assign cw = '{sel_data: sel_data, ir_load: ir_load,
                  pc_inc: pc_inc, pc_rel: pc_rel};

    sfa_ctl_decode u_dec (
        .cw  (cw),
        .dec (dec)
    );

    sfa_addr_mux #(.ADDR_W(ADDR_W)) u_mux (
        .src      (dec.src),
        .pc_addr  (pc),
        .bus_addr (bus_a),
        .addr     (mem_addr)
    );

    sfa_instr_reg #(.INSTR_W(INSTR_W)) u_ir (
        .clk (clk),
        .rst (rst),
        .we  (dec.ir_we),
        .d   (mem_rdata),
        .q   (instr)
    );

    sfa_pc_unit #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_pc (
        .clk    (clk),
        .rst    (rst),
        .op     (dec.pc_op),
        .offset (instr[OFF_LSB +: OFF_W]),
        .pc     (pc)
    );
endmodule

// File: rtl/sfa_fetch_path_chk.sv
module sfa_fetch_path_chk #(
    parameter int unsigned ADDR_W  = 16,
    parameter int unsigned INSTR_W = 16,
    parameter int unsigned OFF_W   = 6,
    parameter int unsigned OFF_LSB = 0
) (
    input logic               clk,
    input logic               rst,
    input logic               sel_data,
    input logic               ir_load,
    input logic               pc_inc,
    input logic               pc_rel,
    input logic [ADDR_W-1:0]  bus_a,
    input logic [INSTR_W-1:0] mem_rdata,
    input logic [ADDR_W-1:0]  mem_addr,
    input logic [INSTR_W-1:0] instr,
    input logic [ADDR_W-1:0]  pc
);
    logic [ADDR_W-1:0] off_sx;
    assign off_sx = ADDR_W'($signed(instr[OFF_LSB +: OFF_W]));

    AST_ADDR_FETCH: assert property (@(posedge clk) disable iff (rst)
        !sel_data |-> mem_addr == pc);                                  // R1
    AST_ADDR_DATA: assert property (@(posedge clk) disable iff (rst)
        sel_data |-> mem_addr == bus_a);                                // R2
    AST_IR_LOAD: assert property (@(posedge clk) disable iff (rst)
        (ir_load && !sel_data) |=> instr == $past(mem_rdata));          // R3
    AST_IR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(ir_load && !sel_data) |=> $stable(instr));                    // R4
    AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
        (pc_inc && !pc_rel && !sel_data) |=> pc == $past(pc) + ADDR_W'(1)); // R5
    AST_PC_BRANCH: assert property (@(posedge clk) disable iff (rst)
        (pc_rel && !sel_data) |=> pc == $past(pc) + $past(off_sx));     // R6
    AST_PC_PRIO: assert property (@(posedge clk) disable iff (rst)
        (pc_rel && pc_inc && !sel_data) |=> pc == $past(pc) + $past(off_sx)); // R7
    AST_PC_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (sel_data || (!pc_inc && !pc_rel)) |=> $stable(pc));            // R8
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (pc == '0 && instr == '0));                             // R9
endmodule

bind sfa_fetch_path sfa_fetch_path_chk #(
    .ADDR_W(ADDR_W), .INSTR_W(INSTR_W), .OFF_W(OFF_W), .OFF_LSB(OFF_LSB)
) u_chk (
    .clk(clk), .rst(rst), .sel_data(sel_data), .ir_load(ir_load),
    .pc_inc(pc_inc), .pc_rel(pc_rel), .bus_a(bus_a), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .instr(instr), .pc(pc)
);

// File: tb/sfa_fetch_path_bench.sv
module sfa_fetch_path_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        sel_data, ir_load, pc_inc, pc_rel;
    logic [15:0] bus_a, mem_rdata;
    logic [15:0] mem_addr, instr, pc;

    int checks = 0;
    int fails  = 0;
    logic [15:0] m_pc, m_ir;

    always #2 clk = ~clk;

    sfa_fetch_path u_sfa_fetch_path (
        .clk(clk), .rst(rst), .sel_data(sel_data), .ir_load(ir_load),
        .pc_inc(pc_inc), .pc_rel(pc_rel), .bus_a(bus_a), .mem_rdata(mem_rdata),
        .mem_addr(mem_addr), .instr(instr), .pc(pc)
    );

    function automatic logic [15:0] f_next_pc(input logic [15:0] p, input logic [15:0] ir,
                                              input logic sd, input logic inc, input logic rel);
        logic [15:0] off;
        off = {{10{ir[5]}}, ir[5:0]};
        if (sd)       return p;
        else if (rel) return p + off;
        else if (inc) return p + 16'd1;
        else          return p;
    endfunction

    function automatic logic [15:0] f_next_ir(input logic [15:0] ir, input logic [15:0] rd,
                                              input logic sd, input logic ld);
        return (ld && !sd) ? rd : ir;
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One cycle: drive at negedge, check address, clock, then check state.
    task automatic step(input logic sd, input logic ld, input logic inc, input logic rel,
                        input logic [15:0] ba, input logic [15:0] rd, input string req);
        sel_data = sd; ir_load = ld; pc_inc = inc; pc_rel = rel;
        bus_a = ba; mem_rdata = rd;
        #1;
        if (sd) chk("R2 addr", mem_addr, ba);
        else    chk("R1 addr", mem_addr, m_pc);
        m_pc = f_next_pc(m_pc, m_ir, sd, inc, rel);
        m_ir = f_next_ir(m_ir, rd, sd, ld);
        @(negedge clk);
        chk({req, " pc"}, pc, m_pc);
        chk({req, " instr"}, instr, m_ir);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_pc = '0;
        m_ir = '0;
        chk("R9 pc", pc, 16'h0);
        chk("R9 instr", instr, 16'h0);
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        sel_data = 0; ir_load = 0; pc_inc = 0; pc_rel = 0; bus_a = 0; mem_rdata = 0;
        @(negedge clk);
        do_reset();

        // R3/R4: load then hold through idle and data cycles with load bit set
        step(0, 1, 0, 0, 16'h1111, 16'hABFC, "R3 load");
        step(0, 0, 0, 0, 16'h2222, 16'h5555, "R4 hold idle");
        step(1, 1, 1, 1, 16'hBEEF, 16'h7777, "R4 R8 data cycle");
        // R5: increments
        step(0, 0, 1, 0, 16'h0, 16'h0, "R5 inc");
        step(0, 0, 1, 0, 16'h0, 16'h0, "R5 inc");
        step(0, 0, 1, 0, 16'h0, 16'h0, "R5 inc");
        // R6: negative offset (-4) wraps below zero
        step(0, 0, 0, 1, 16'h0, 16'h0, "R6 neg branch");
        step(0, 0, 0, 1, 16'h0, 16'h0, "R6 neg branch wrap");
        // R7: both set, branch wins
        step(0, 0, 1, 1, 16'h0, 16'h0, "R7 prio");
        // positive maximum offset +31
        step(0, 1, 0, 0, 16'h0, 16'h001F, "R3 load");
        step(0, 0, 1, 1, 16'h0, 16'h0, "R7 prio pos");
        // load and branch same edge: old instr offset used
        step(0, 1, 0, 1, 16'h0, 16'h0020, "R6 old offset");
        step(0, 0, 0, 1, 16'h0, 16'h0, "R6 min offset");
        step(1, 0, 1, 0, 16'h1234, 16'h0, "R8 data inc");

        for (int i = 0; i < 3000; i++) begin
            logic [3:0] c;
            c = 4'($urandom);
            step(c[0], c[1], c[2], c[3], 16'($urandom), 16'($urandom), "R1-mix random");
            if (($urandom % 500) == 0) do_reset();
        end

        do_reset();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule